// File: doc/BRIEF.md
# Recently Evicted Set Tracker

This block sits beside a small first-level data cache and watches its misses in order to spot sets that keep losing their line and then missing on it again. It keeps a short ring of the set indices that were most recently evicted. Each time the cache reports a miss, the block compares the missed index against every valid ring entry at the same moment. A match means the set was evicted a short while ago and is now wanted back, which points to thrashing.

When a match is found, the block raises a one-cycle pulse that carries the set index. The cache uses this pulse to turn on the expanded lookup for that set. Whether or not a match is found, the missed index is then written into the ring at the head position, replacing the oldest entry. The block does nothing on hits, so it adds no logic to the hit path.

The ring depth and the index width are parameters. Five entries suit a direct-mapped cache and eight suit a four-way cache. The default is five entries of 8-bit indices, which covers 256 sets.

Top module: `evict_set_tracker`

## Requirements
- R1: After reset, every ring entry is invalid, and `thrash_pulse` and `thrash_set` are 0. A miss on any index, including index 0, does not produce a pulse until that index has been written by an earlier miss.
- R2: A cycle with `miss_strobe` low changes nothing. No pulse follows it, and an index recorded before any number of idle cycles still matches afterwards.
- R3: A miss whose index equals a valid ring entry makes `thrash_pulse` 1 in the cycle after the miss, with `thrash_set` equal to that index.
- R4: A miss whose index equals no valid entry leaves `thrash_pulse` at 0 in the following cycle.
- R5: Every miss writes its index at the head, and the head then advances modulo DEPTH. After DEPTH later misses, an index no longer matches. An index written exactly DEPTH−1 misses earlier still matches.
- R6: A miss that matches is still written again at the head, which refreshes its age in the ring.
- R7: `thrash_pulse` lasts one cycle and is 1 only in the cycle right after a cycle with `miss_strobe` high.
- R8: `thrash_set` is 0 whenever `thrash_pulse` is 0.
- R9: On back-to-back misses, the second miss is compared against a ring that already holds the first miss's index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| miss_strobe | input | 1 | High for one cycle per cache miss |
| miss_set | input | IDX_W | Set index of the miss; this set is also the one evicted |
| thrash_pulse | output | 1 | One-cycle pulse: the missed set was found in the ring |
| thrash_set | output | IDX_W | Index of the thrashing set while the pulse is high, otherwise 0 |

## Verification
The embedded assertions check the following on every cycle:
- the head pointer stays within range;
- the ring is frozen while no miss arrives;
- a pulse always follows a miss and carries that miss's index;
- `thrash_set` is 0 when there is no pulse;
- a pulse can never come from an empty ring.

Some behaviours depend on the order of misses and can only be shown by the bench's scenarios. These are the point at which an entry ages out of the ring, the refresh of a matching index, and the match on a miss that comes right after another. The bench covers them with directed sequences and a long random stream drawn from a small set of indices, all compared against a queue model.

// File: rtl/evtrk_pkg.sv
package evtrk_pkg;

    localparam int unsigned DEF_IDX_W = 8;
    localparam int unsigned DEF_DEPTH = 5;

    // Position following p in a ring of the given depth.
    function automatic int unsigned ring_next(input int unsigned p, input int unsigned depth);
        return (p + 1 >= depth) ? 0 : p + 1;
    endfunction

endpackage

// File: rtl/evtrk_ring.sv
module evtrk_ring
    import evtrk_pkg::*;
#(
    parameter int unsigned IDX_W = DEF_IDX_W,
    parameter int unsigned DEPTH = DEF_DEPTH
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    output logic [DEPTH-1:0][IDX_W-1:0] slot_idx,
    output logic [DEPTH-1:0]            slot_vld
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][IDX_W-1:0] idx;
        logic [DEPTH-1:0]            vld;
        logic [PTR_W-1:0]            head;
    } ring_t;

    ring_t            st_d, st_q;
    logic [DEPTH-1:0] wr_sel;

    // One write select per slot, decoded from the head pointer.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign wr_sel[g] = wr_en && (st_q.head == PTR_W'(g));
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (wr_sel[i]) begin
                st_d.idx[i] = wr_idx;
                st_d.vld[i] = 1'b1;
            end
        end
        if (wr_en) begin
            st_d.head = PTR_W'(ring_next(st_q.head, DEPTH));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign slot_idx = st_q.idx;
    assign slot_vld = st_q.vld;

    // R5: the head pointer never leaves 0..DEPTH-1.
    assert_head_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, st_q.head} < (PTR_W+1)'(DEPTH));

    // R2: no write request, no change anywhere in the ring.
    assert_idle_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q));

    // R5: entries never turn invalid once written.
    assert_valid_monotone_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_q.vld) >= $countones($past(st_q.vld)));

    // R1: after a write, at least one entry is valid.
    assert_write_fills_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (st_q.vld != '0));

endmodule

// File: rtl/evtrk_match.sv
module evtrk_match
    import evtrk_pkg::*;
#(
    parameter int unsigned IDX_W = DEF_IDX_W,
    parameter int unsigned DEPTH = DEF_DEPTH
) (
    input  logic [DEPTH-1:0][IDX_W-1:0] slot_idx,
    input  logic [DEPTH-1:0]            slot_vld,
    input  logic [IDX_W-1:0]            key,
    output logic                        hit
);

    logic [DEPTH-1:0] eq;

    // One comparator per slot, all evaluated in parallel.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign eq[g] = slot_vld[g] && (slot_idx[g] == key);
    end

    assign hit = |eq;

endmodule

// File: rtl/evtrk_flag.sv
module evtrk_flag
    import evtrk_pkg::*;
#(
    parameter int unsigned IDX_W = DEF_IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             probe,
    input  logic             hit,
    input  logic [IDX_W-1:0] probe_idx,
    output logic             pulse,
    output logic [IDX_W-1:0] pulse_idx
);

    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] idx;
    } flag_t;

    flag_t fl_d, fl_q;

    always_comb begin
        fl_d.vld = probe && hit;
        fl_d.idx = (probe && hit) ? probe_idx : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign pulse     = fl_q.vld;
    assign pulse_idx = fl_q.idx;

    // R7: a pulse only follows a cycle with a probe.
    assert_pulse_after_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> $past(probe));

    // R3: the pulse carries the probed index.
    assert_pulse_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> (pulse_idx == $past(probe_idx)));

    // R8: index output is zero when no pulse.
    assert_idle_index_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse |-> (pulse_idx == '0));

endmodule

// File: rtl/evict_set_tracker.sv
module evict_set_tracker
    import evtrk_pkg::*;
#(
    parameter int unsigned IDX_W = DEF_IDX_W,
    parameter int unsigned DEPTH = DEF_DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             miss_strobe,
    input  logic [IDX_W-1:0] miss_set,
    output logic             thrash_pulse,
    output logic [IDX_W-1:0] thrash_set
);

    logic [DEPTH-1:0][IDX_W-1:0] slot_idx;
    logic [DEPTH-1:0]            slot_vld;
    logic                        hit;

    evtrk_ring #(.IDX_W(IDX_W), .DEPTH(DEPTH)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (miss_strobe),
        .wr_idx   (miss_set),
        .slot_idx (slot_idx),
        .slot_vld (slot_vld)
    );

    evtrk_match #(.IDX_W(IDX_W), .DEPTH(DEPTH)) u_match (
        .slot_idx (slot_idx),
        .slot_vld (slot_vld),
        .key      (miss_set),
        .hit      (hit)
    );

    evtrk_flag #(.IDX_W(IDX_W)) u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .probe     (miss_strobe),
        .hit       (hit),
        .probe_idx (miss_set),
        .pulse     (thrash_pulse),
        .pulse_idx (thrash_set)
    );

    // R1: an empty ring can never produce a pulse.
    assert_empty_no_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        thrash_pulse |-> ($past(slot_vld) != '0));

    // R3: a matching miss is always followed by a pulse.
    assert_match_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_strobe && hit) |=> thrash_pulse);

    // R4: a non-matching miss is followed by no pulse.
    assert_nomatch_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_strobe && !hit) |=> !thrash_pulse);

endmodule

// File: tb/evict_set_tracker_bench.sv
module evict_set_tracker_bench;

    localparam int CLK_PERIOD = 10;
    localparam int IDX_W      = 8;
    localparam int DEPTH      = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             miss_strobe = 1'b0;
    logic [IDX_W-1:0] miss_set = '0;
    logic             thrash_pulse;
    logic [IDX_W-1:0] thrash_set;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evict_set_tracker #(.IDX_W(IDX_W), .DEPTH(DEPTH)) u_evict_set_tracker (
        .clk          (clk),
        .rst_n        (rst_n),
        .miss_strobe  (miss_strobe),
        .miss_set     (miss_set),
        .thrash_pulse (thrash_pulse),
        .thrash_set   (thrash_set)
    );

    // Behavioural reference: a queue of recent indices, oldest at the front.
    logic [IDX_W-1:0] model_q[$];
    bit               exp_vld = 1'b0;
    logic [IDX_W-1:0] exp_set = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            model_q.delete();
            exp_vld <= 1'b0;
            exp_set <= '0;
        end else if (miss_strobe) begin
            bit found;
            found = 1'b0;
            foreach (model_q[i]) if (model_q[i] == miss_set) found = 1'b1;
            exp_vld <= found;
            exp_set <= found ? miss_set : '0;
            model_q.push_back(miss_set);
            if (model_q.size() > DEPTH) void'(model_q.pop_front());
        end else begin
            exp_vld <= 1'b0;
            exp_set <= '0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Model comparison on every cycle, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(thrash_pulse == exp_vld && thrash_set == exp_set,
                  "R3 R4 R8 model compare",
                  int'({thrash_pulse, thrash_set}), int'({exp_vld, exp_set}));
        end
    end

    task automatic expect_out(input bit v, input logic [IDX_W-1:0] s, input string req);
        check(thrash_pulse == v && thrash_set == s, req,
              int'({thrash_pulse, thrash_set}), int'({v, s}));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        miss_strobe = 1'b0;
        miss_set = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Miss for one cycle; returns at the negedge where the result is visible.
    task automatic one_miss(input logic [IDX_W-1:0] idx);
        @(negedge clk);
        miss_strobe = 1'b1;
        miss_set = idx;
        @(negedge clk);
        miss_strobe = 1'b0;
        miss_set = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out(1'b0, 8'd0, "R1 reset outputs");
        one_miss(8'd0);
        expect_out(1'b0, 8'd0, "R1 empty ring ignores index 0");

        // R3 / R4 / R7
        do_reset();
        one_miss(8'd7);
        expect_out(1'b0, 8'd0, "R4 first miss no match");
        one_miss(8'd7);
        expect_out(1'b1, 8'd7, "R3 repeat miss flags");
        @(negedge clk);
        expect_out(1'b0, 8'd0, "R7 pulse lasts one cycle");

        // R9 back-to-back
        do_reset();
        @(negedge clk);
        miss_strobe = 1'b1;
        miss_set = 8'd9;
        @(negedge clk);
        expect_out(1'b0, 8'd0, "R9 first of pair");
        @(negedge clk);
        miss_strobe = 1'b0;
        miss_set = '0;
        expect_out(1'b1, 8'd9, "R9 second of pair matches");

        // R5 ageing out and boundary
        do_reset();
        for (int k = 10; k <= 15; k++) one_miss(8'(k));
        one_miss(8'd10);
        expect_out(1'b0, 8'd0, "R5 oldest entry overwritten");
        one_miss(8'd12);
        expect_out(1'b1, 8'd12, "R5 entry at depth boundary still held");

        // R6 refresh
        do_reset();
        for (int k = 20; k <= 24; k++) one_miss(8'(k));
        one_miss(8'd20);
        expect_out(1'b1, 8'd20, "R6 match before refresh");
        for (int k = 30; k <= 33; k++) one_miss(8'(k));
        one_miss(8'd20);
        expect_out(1'b1, 8'd20, "R6 refreshed entry survives");

        // R2 idle cycles
        do_reset();
        one_miss(8'd40);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            expect_out(1'b0, 8'd0, "R2 idle no pulse");
        end
        one_miss(8'd40);
        expect_out(1'b1, 8'd40, "R2 entry kept across idle");

        // Random stream over a narrow index range, checked by the model.
        do_reset();
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            miss_strobe = ($urandom_range(0, 3) != 0);
            miss_set = 8'($urandom_range(0, 11));
        end
        @(negedge clk);
        miss_strobe = 1'b0;
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog R1-timeout actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

endmodule